// File: doc/BRIEF.md
# Segmented Entry Load/Unload Sequencer

This block carries an 80-bit table entry across a data port that is only 16 or 32 bits wide. The entry is split at a configurable bit position into a lookup part (CAM, low side) and an associated-data part (RAM). On the load side, host words are collected into an entry register, CAM words first, then RAM words, each least significant word first. Every word carries a 3-bit tag. A plain-load tag only stores the word. An operation tag stores the word and also launches that operation towards a downstream engine through a request/acknowledge handshake.

On the unload side, the engine's response is held in a response register and returned one word per read strobe. A search returns only its RAM words. A queue read returns its CAM words and then its RAM words, and its first word appears at the output in the same cycle the request is accepted. Insert and learn return nothing. The host may stop reading at any time. Starting a new load throws away whatever was left unread.

The controller is a four-state machine. `ST_IDLE` means nothing is pending. `ST_GATHER` means a load has started and no operation tag has arrived yet. `ST_ISSUE` means a search, insert or learn is waiting for the engine's acknowledge. `ST_DRAIN` means response words may still be unread.

Its transitions are:
- IDLE/GATHER/DRAIN → GATHER on an accepted plain-load word.
- IDLE/GATHER/DRAIN → ISSUE on an accepted search, insert or learn word.
- IDLE/GATHER/DRAIN → DRAIN on an acknowledged queue read.
- ISSUE → DRAIN on the acknowledge of a search.
- ISSUE → IDLE on the acknowledge of an insert or learn.
- DRAIN → IDLE once no words remain.

Top module: `seg_entry_seq`

## Requirements
- R1: While reset is held and after it is released, with no stimulus applied, `out_avail`, `eng_req` and `in_ready` are 0 and `out_word` is 0.
- R2: Load word number i, counted from 0 and accepted since the load began, is handled as follows. For i < ceil(c/w) it fills CAM bits [i*w +: w]. For the next ceil((80-c)/w) words, with r = i - ceil(c/w), it fills RAM bits [r*w +: w]. Here c is `cfg_cam_bits`, with any value above 80 taken as 80, and w is 32 when `cfg_in_wide`=1 and 16 otherwise. In 16-bit mode bits [31:16] of `in_word` are ignored.
- R3: Tag codes are: 0, 6 and 7 plain load; 1 search; 2 insert; 3 learn; 4 and 5 the two queue reads. A word tagged 1 to 3 is stored and then `eng_req` stays high with `eng_op` equal to the tag until `eng_ack`.
- R4: `in_ready` is 1 for a presented plain-load or search/insert/learn word outside ISSUE. It is 0 throughout ISSUE. A queue-read word raises `eng_req` immediately and is accepted only in the cycle `eng_ack` is high.
- R5: Each load clears the entry register on its first word. `eng_cam`/`eng_ram` therefore carry zero in every bit that was not supplied, including unsupplied RAM words for insert and learn. Words beyond the last RAM word are accepted and dropped.
- R6: After a search is acknowledged, reads return the words of `eng_rsp_ram` as sampled at the acknowledge, least significant first, ceil((80-c)/w_out) words in all. Here w_out is 32 when `cfg_out_wide`=1 and 16 otherwise.
- R7: In the cycle a queue read is acknowledged, `out_avail`=1 and `out_word` is the first word of the CAM-then-RAM sequence. Following reads return the remaining words of that sequence in order.
- R8: Output bits that lie above the end of a segment are 0. This covers the upper bits of a segment's last word and bits [31:16] in 16-bit output mode.
- R9: A read strobe while `out_avail`=1 consumes one word. Reads may stop early. When the first word of a new load is accepted, all unread words are discarded.
- R10: The partition and input width are taken from the configuration inputs when a load's first word is accepted and hold for the rest of that load. The output width and, for a queue read, the partition are taken when the response is captured.
- R11: Insert and learn leave no words to unload once acknowledged.
- R12: `out_word` is 0 whenever `out_avail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cam_bits | input | 7 | CAM/RAM split position (bits of CAM) |
| cfg_in_wide | input | 1 | Load port width: 1 = 32, 0 = 16 |
| cfg_out_wide | input | 1 | Unload port width: 1 = 32, 0 = 16 |
| in_valid | input | 1 | Load word presented |
| in_tag | input | 3 | Word tag (plain load or operation) |
| in_word | input | 32 | Load data, right-aligned |
| in_ready | output | 1 | Presented word accepted this cycle |
| eng_req | output | 1 | Operation request to engine |
| eng_op | output | 3 | Requested operation code |
| eng_cam | output | 80 | Gathered CAM segment |
| eng_ram | output | 80 | Gathered RAM segment |
| eng_ack | input | 1 | Engine accepts request / response valid |
| eng_rsp_cam | input | 80 | Engine response CAM segment |
| eng_rsp_ram | input | 80 | Engine response RAM segment |
| out_rd | input | 1 | Read strobe for unload |
| out_word | output | 32 | Current unload word |
| out_avail | output | 1 | A word is available at out_word |

## Verification
The load path is driven with random split positions from 0 to 80, both input widths, a random number of RAM words (including none), and an occasional surplus word. This separates a correct mapping of word index to segment from one that is off by a word or one that lets surplus or upper-half data leak into the entry. Unloads mix both output widths and both response orderings, and they stop after a random number of reads. This shows whether the pointer, the segment order and the upper-bit zeroing are right. Directed cases cover the edges: a split at 0 and at 80, an out-of-range split, a configuration change in the middle of a load, an insert with no RAM words, and a new load issued while words are still unread.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int ENTRY_W   = 80;
    localparam int PORT_MAX  = 32;
    localparam int PORT_MIN  = 16;
    localparam int CNT_W     = $clog2(ENTRY_W + 1);
    localparam int SEGI_W    = 3;
    localparam int LDI_W     = 4;
    localparam int SH_WIDE   = $clog2(PORT_MAX);
    localparam int SH_NARROW = $clog2(PORT_MIN);

    typedef enum logic [2:0] {
        TAG_LOAD    = 3'd0,
        TAG_SEARCH  = 3'd1,
        TAG_INSERT  = 3'd2,
        TAG_LEARN   = 3'd3,
        TAG_QREAD_L = 3'd4,
        TAG_QREAD_A = 3'd5,
        TAG_RSV6    = 3'd6,
        TAG_RSV7    = 3'd7
    } tag_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_ISSUE  = 2'd2,
        ST_DRAIN  = 2'd3
    } st_e;

    function automatic logic [CNT_W-1:0] clamp_bits(input logic [CNT_W-1:0] bits);
        return (bits > CNT_W'(ENTRY_W)) ? CNT_W'(ENTRY_W) : bits;
    endfunction

    function automatic logic [SEGI_W-1:0] seg_words(input logic [CNT_W-1:0] bits,
                                                    input logic wide);
        logic [CNT_W:0] t;
        if (wide) t = ({1'b0, bits} + (CNT_W+1)'(PORT_MAX - 1)) >> SH_WIDE;
        else      t = ({1'b0, bits} + (CNT_W+1)'(PORT_MIN - 1)) >> SH_NARROW;
        return t[SEGI_W-1:0];
    endfunction

    function automatic logic [ENTRY_W-1:0] seg_mask(input logic [CNT_W-1:0] bits);
        if (bits >= CNT_W'(ENTRY_W)) return '1;
        return (ENTRY_W'(1) << bits) - ENTRY_W'(1);
    endfunction

    function automatic logic [PORT_MAX-1:0] port_mask(input logic wide);
        return wide ? '1 : PORT_MAX'((64'd1 << PORT_MIN) - 64'd1);
    endfunction

    function automatic logic [CNT_W:0] word_start(input logic [SEGI_W-1:0] k,
                                                  input logic wide);
        return wide ? ((CNT_W+1)'(k) << SH_WIDE) : ((CNT_W+1)'(k) << SH_NARROW);
    endfunction

    function automatic logic [ENTRY_W-1:0] place_word(input logic [PORT_MAX-1:0] word,
                                                      input logic [SEGI_W-1:0] k,
                                                      input logic wide,
                                                      input logic [CNT_W-1:0] bits);
        logic [ENTRY_W-1:0] ext;
        ext = ENTRY_W'(word & port_mask(wide));
        return (ext << word_start(k, wide)) & seg_mask(bits);
    endfunction

    function automatic logic [PORT_MAX-1:0] seg_word(input logic [ENTRY_W-1:0] seg,
                                                     input logic [SEGI_W-1:0] k,
                                                     input logic wide,
                                                     input logic [CNT_W-1:0] bits);
        logic [CNT_W:0]       start;
        logic [CNT_W:0]       left;
        logic [CNT_W:0]       keep;
        logic [ENTRY_W-1:0]   sh;
        logic [PORT_MAX-1:0]  m;
        start = word_start(k, wide);
        sh    = seg >> start;
        left  = ({1'b0, bits} > start) ? ({1'b0, bits} - start) : '0;
        keep  = wide ? (CNT_W+1)'(PORT_MAX) : (CNT_W+1)'(PORT_MIN);
        if (left < keep) keep = left;
        if (keep >= (CNT_W+1)'(PORT_MAX)) m = '1;
        else m = (PORT_MAX'(1) << keep) - PORT_MAX'(1);
        return sh[PORT_MAX-1:0] & m;
    endfunction

endpackage

// File: rtl/seq_load_gather.sv
module seq_load_gather
    import seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 first,
    input  logic [PORT_MAX-1:0]  word,
    input  logic                 cfg_wide,
    input  logic [CNT_W-1:0]     cfg_bits,
    output logic [ENTRY_W-1:0]   ent_cam,
    output logic [ENTRY_W-1:0]   ent_ram,
    output logic [CNT_W-1:0]     lat_bits
);

    logic [LDI_W-1:0]   idx_q;
    logic [CNT_W-1:0]   bits_q;
    logic               wide_q;
    logic [ENTRY_W-1:0] cam_q;
    logic [ENTRY_W-1:0] ram_q;

    logic [CNT_W-1:0]   bits_e;
    logic [CNT_W-1:0]   rbits_e;
    logic               wide_e;
    logic [LDI_W-1:0]   i_e;
    logic [LDI_W-1:0]   ri_e;
    logic [SEGI_W-1:0]  ncam_e;
    logic [SEGI_W-1:0]  nram_e;
    logic               to_cam;
    logic               to_ram;
    logic [ENTRY_W-1:0] pw_cam;
    logic [ENTRY_W-1:0] pw_ram;

    always_comb begin
        bits_e  = first ? cfg_bits : bits_q;
        wide_e  = first ? cfg_wide : wide_q;
        rbits_e = CNT_W'(ENTRY_W) - bits_e;
        i_e     = first ? '0 : idx_q;
        ncam_e  = seg_words(bits_e, wide_e);
        nram_e  = seg_words(rbits_e, wide_e);
        to_cam  = i_e < LDI_W'(ncam_e);
        ri_e    = i_e - LDI_W'(ncam_e);
        to_ram  = !to_cam && (ri_e < LDI_W'(nram_e));
        pw_cam  = place_word(word, SEGI_W'(i_e), wide_e, bits_e);
        pw_ram  = place_word(word, SEGI_W'(ri_e), wide_e, rbits_e);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            bits_q <= '0;
            wide_q <= 1'b0;
            cam_q  <= '0;
            ram_q  <= '0;
        end else if (wr) begin
            idx_q <= (i_e == '1) ? i_e : i_e + 1'b1;
            if (first) begin
                bits_q <= cfg_bits;
                wide_q <= cfg_wide;
                cam_q  <= to_cam ? pw_cam : '0;
                ram_q  <= to_ram ? pw_ram : '0;
            end else begin
                cam_q  <= cam_q | (to_cam ? pw_cam : '0);
                ram_q  <= ram_q | (to_ram ? pw_ram : '0);
            end
        end
    end

    assign ent_cam  = cam_q;
    assign ent_ram  = ram_q;
    assign lat_bits = bits_q;

    AST_CFG_HELD_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !first |=> bits_q == $past(bits_q) && wide_q == $past(wide_q)); // R10

    AST_RAM_ABOVE_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ram_q & ~seg_mask(CNT_W'(ENTRY_W) - bits_q)) == '0); // R8

endmodule

// File: rtl/seq_unload_ser.sv
module seq_unload_ser
    import seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap,
    input  logic                 cap_queue,
    input  logic [CNT_W-1:0]     cap_bits,
    input  logic                 cap_wide,
    input  logic [ENTRY_W-1:0]   rsp_cam,
    input  logic [ENTRY_W-1:0]   rsp_ram,
    input  logic                 flush,
    input  logic                 rd,
    output logic                 more,
    output logic [PORT_MAX-1:0]  out_word,
    output logic                 out_avail
);

    logic [ENTRY_W-1:0] cam_q;
    logic [ENTRY_W-1:0] ram_q;
    logic               queue_q;
    logic [CNT_W-1:0]   bits_q;
    logic               wide_q;
    logic [LDI_W-1:0]   ptr_q;
    logic [LDI_W-1:0]   total_q;

    logic [LDI_W-1:0]   cap_total;
    logic               bypass;
    logic               adv;

    function automatic logic [PORT_MAX-1:0] word_at(input logic [ENTRY_W-1:0] cam,
                                                    input logic [ENTRY_W-1:0] ram,
                                                    input logic q,
                                                    input logic [LDI_W-1:0] idx,
                                                    input logic w,
                                                    input logic [CNT_W-1:0] b);
        logic [SEGI_W-1:0] nc;
        logic [LDI_W-1:0]  ri;
        nc = seg_words(b, w);
        if (q && idx < LDI_W'(nc)) return seg_word(cam, SEGI_W'(idx), w, b);
        ri = q ? idx - LDI_W'(nc) : idx;
        return seg_word(ram, SEGI_W'(ri), w, CNT_W'(ENTRY_W) - b);
    endfunction

    always_comb begin
        cap_total = LDI_W'(seg_words(CNT_W'(ENTRY_W) - cap_bits, cap_wide));
        if (cap_queue) cap_total = cap_total + LDI_W'(seg_words(cap_bits, cap_wide));
        bypass = cap && cap_queue;
        more   = ptr_q < total_q;
        adv    = rd && more && !cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cam_q   <= '0;
            ram_q   <= '0;
            queue_q <= 1'b0;
            bits_q  <= '0;
            wide_q  <= 1'b0;
            ptr_q   <= '0;
            total_q <= '0;
        end else if (cap) begin
            cam_q   <= rsp_cam;
            ram_q   <= rsp_ram;
            queue_q <= cap_queue;
            bits_q  <= cap_bits;
            wide_q  <= cap_wide;
            ptr_q   <= cap_queue ? LDI_W'(1) : '0;
            total_q <= cap_total;
        end else if (flush) begin
            ptr_q   <= '0;
            total_q <= '0;
        end else if (adv) begin
            ptr_q   <= ptr_q + 1'b1;
        end
    end

    always_comb begin
        if (bypass) begin
            out_avail = 1'b1;
            out_word  = word_at(rsp_cam, rsp_ram, 1'b1, '0, cap_wide, cap_bits);
        end else if (more) begin
            out_avail = 1'b1;
            out_word  = word_at(cam_q, ram_q, queue_q, ptr_q, wide_q, bits_q);
        end else begin
            out_avail = 1'b0;
            out_word  = '0;
        end
    end

    AST_PTR_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= total_q || total_q == '0 && ptr_q <= LDI_W'(1)); // R9

    AST_FLUSH_DROPS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !cap |=> !more); // R9

    AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_avail |-> out_word == '0); // R12

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        more && !wide_q && !cap |-> out_word[PORT_MAX-1:PORT_MIN] == '0); // R8

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
    import seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [2:0]  in_tag,
    input  logic        eng_ack,
    input  logic        more,
    output logic        in_ready,
    output logic        first,
    output logic        wr,
    output logic        flush,
    output logic        eng_req,
    output logic [2:0]  eng_op,
    output logic        cap,
    output logic        cap_queue
);

    st_e  st_q;
    st_e  st_d;
    tag_e op_q;
    tag_e tag_in;
    logic is_q;
    logic is_op;
    logic acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            op_q <= TAG_LOAD;
        end else begin
            st_q <= st_d;
            if (acc && is_op) op_q <= tag_in;
        end
    end

    always_comb begin
        tag_in    = tag_e'(in_tag);
        is_q      = (tag_in == TAG_QREAD_L) || (tag_in == TAG_QREAD_A);
        is_op     = (tag_in == TAG_SEARCH) || (tag_in == TAG_INSERT) ||
                    (tag_in == TAG_LEARN);
        in_ready  = 1'b0;
        eng_req   = 1'b0;
        eng_op    = in_tag;
        cap       = 1'b0;
        cap_queue = 1'b0;
        st_d      = st_q;
        unique case (st_q)
            ST_IDLE, ST_GATHER, ST_DRAIN: begin
                if (st_q == ST_DRAIN && !more) st_d = ST_IDLE;
                if (in_valid) begin
                    if (is_q) begin
                        eng_req  = 1'b1;
                        in_ready = eng_ack;
                        if (eng_ack) begin
                            cap       = 1'b1;
                            cap_queue = 1'b1;
                            st_d      = ST_DRAIN;
                        end
                    end else begin
                        in_ready = 1'b1;
                        st_d     = is_op ? ST_ISSUE : ST_GATHER;
                    end
                end
            end
            ST_ISSUE: begin
                eng_req = 1'b1;
                eng_op  = op_q;
                if (eng_ack) begin
                    cap  = (op_q == TAG_SEARCH);
                    st_d = (op_q == TAG_SEARCH) ? ST_DRAIN : ST_IDLE;
                end
            end
        endcase
        acc   = in_valid && in_ready;
        first = (st_q != ST_GATHER);
        wr    = acc && !is_q;
        flush = wr && first;
    end

    AST_NO_ACCEPT_IN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_ISSUE |-> !in_ready); // R4

    AST_REQ_HELD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_ISSUE && !eng_ack |=> eng_req && eng_op == $past(eng_op)); // R3

    AST_OP_ENTERS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && is_op |=> st_q == ST_ISSUE); // R3

endmodule

// File: rtl/seg_entry_seq.sv
module seg_entry_seq
    import seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_cam_bits,
    input  logic                 cfg_in_wide,
    input  logic                 cfg_out_wide,
    input  logic                 in_valid,
    input  logic [2:0]           in_tag,
    input  logic [PORT_MAX-1:0]  in_word,
    output logic                 in_ready,
    output logic                 eng_req,
    output logic [2:0]           eng_op,
    output logic [ENTRY_W-1:0]   eng_cam,
    output logic [ENTRY_W-1:0]   eng_ram,
    input  logic                 eng_ack,
    input  logic [ENTRY_W-1:0]   eng_rsp_cam,
    input  logic [ENTRY_W-1:0]   eng_rsp_ram,
    input  logic                 out_rd,
    output logic [PORT_MAX-1:0]  out_word,
    output logic                 out_avail
);

    logic             first;
    logic             wr;
    logic             flush;
    logic             cap;
    logic             cap_queue;
    logic             more;
    logic [CNT_W-1:0] bits_live;
    logic [CNT_W-1:0] lat_bits;
    logic [CNT_W-1:0] cap_bits;

    assign bits_live = clamp_bits(cfg_cam_bits);
    assign cap_bits  = cap_queue ? bits_live : lat_bits;

    seq_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_tag    (in_tag),
        .eng_ack   (eng_ack),
        .more      (more),
        .in_ready  (in_ready),
        .first     (first),
        .wr        (wr),
        .flush     (flush),
        .eng_req   (eng_req),
        .eng_op    (eng_op),
        .cap       (cap),
        .cap_queue (cap_queue)
    );

    seq_load_gather u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .first    (first),
        .word     (in_word),
        .cfg_wide (cfg_in_wide),
        .cfg_bits (bits_live),
        .ent_cam  (eng_cam),
        .ent_ram  (eng_ram),
        .lat_bits (lat_bits)
    );

    seq_unload_ser u_unload (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .cap_queue (cap_queue),
        .cap_bits  (cap_bits),
        .cap_wide  (cfg_out_wide),
        .rsp_cam   (eng_rsp_cam),
        .rsp_ram   (eng_rsp_ram),
        .flush     (flush),
        .rd        (out_rd),
        .more      (more),
        .out_word  (out_word),
        .out_avail (out_avail)
    );

    AST_INSERT_LEAVES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_ack && (eng_op == TAG_INSERT || eng_op == TAG_LEARN) |=> !more); // R11

    AST_QREAD_WORD_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_ack && in_ready && (eng_op == TAG_QREAD_L || eng_op == TAG_QREAD_A)
        |-> out_avail); // R7

endmodule

// File: tb/seg_entry_seq_tb.sv
module seg_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_cam_bits = '0;
    logic        cfg_in_wide = 1'b0;
    logic        cfg_out_wide = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_tag = '0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        eng_req;
    logic [2:0]  eng_op;
    logic [79:0] eng_cam;
    logic [79:0] eng_ram;
    logic        eng_ack = 1'b0;
    logic [79:0] eng_rsp_cam = '0;
    logic [79:0] eng_rsp_ram = '0;
    logic        out_rd = 1'b0;
    logic [31:0] out_word;
    logic        out_avail;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    logic [31:0] exp_seq [0:15];

    always #4 clk = ~clk;

    seg_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cam_bits(cfg_cam_bits),
        .cfg_in_wide(cfg_in_wide), .cfg_out_wide(cfg_out_wide),
        .in_valid(in_valid), .in_tag(in_tag), .in_word(in_word),
        .in_ready(in_ready), .eng_req(eng_req), .eng_op(eng_op),
        .eng_cam(eng_cam), .eng_ram(eng_ram), .eng_ack(eng_ack),
        .eng_rsp_cam(eng_rsp_cam), .eng_rsp_ram(eng_rsp_ram),
        .out_rd(out_rd), .out_word(out_word), .out_avail(out_avail)
    );

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nwords(input int bits, input bit wide);
        int w = wide ? 32 : 16;
        return (bits + w - 1) / w;
    endfunction

    function automatic logic [31:0] exp_word(input logic [79:0] seg, input int k,
                                             input bit wide, input int bits);
        logic [31:0] r = '0;
        int w = wide ? 32 : 16;
        for (int b = 0; b < w; b++) begin
            if (k * w + b < bits) r[b] = seg[k * w + b];
        end
        return r;
    endfunction

    function automatic logic [79:0] rnd80();
        return {16'($urandom()), $urandom(), $urandom()};
    endfunction

    task automatic place(inout logic [79:0] seg, input logic [31:0] word, input int k,
                         input bit wide, input int bits);
        int w = wide ? 32 : 16;
        for (int b = 0; b < w; b++) begin
            if (k * w + b < bits) seg[k * w + b] = word[b];
        end
    endtask

    // tag: operation; cbr: raw split; nsup: RAM words supplied (-1 all);
    // rdn: reads to perform (-1 all); flip: change config mid-operation
    task automatic run_op(input logic [2:0] tag, input int cbr, input bit iw, input bit ow,
                          input int nsup, input int extra, input int rdn,
                          input int wait_n, input bit flip);
        int cb, ncam, nram, total, nseq, start, j, r;
        bit isq;
        logic [79:0] xcam, xram, rc, rr;
        logic [31:0] wv;
        cb   = (cbr > 80) ? 80 : cbr;
        isq  = (tag == 3'd4) || (tag == 3'd5);
        ncam = nwords(cb, iw);
        nram = nwords(80 - cb, iw);
        if (nsup < 0 || nsup > nram) nsup = nram;
        xcam = '0;
        xram = '0;
        rc   = rnd80();
        rr   = rnd80();
        @(negedge clk);
        cfg_cam_bits = 7'(cbr);
        cfg_in_wide  = iw;
        cfg_out_wide = ow;
        if (!isq) begin
            total = ncam + nsup + extra;
            if (total == 0) total = 1;
            for (int i = 0; i < total; i++) begin
                wv = $urandom();
                in_valid = 1'b1;
                in_word  = wv;
                case ($urandom_range(0, 3))
                    0: in_tag = 3'd6;
                    1: in_tag = 3'd7;
                    default: in_tag = 3'd0;
                endcase
                if (i == total - 1) in_tag = tag;
                #1 check("R4 load word accepted", 80'(in_ready), 80'(1));
                if (i < ncam) place(xcam, wv, i, iw, cb);
                else begin
                    r = i - ncam;
                    if (r < nram) place(xram, wv, r, iw, 80 - cb);
                end
                @(posedge clk);
                @(negedge clk);
                if (i == 0) begin
                    #1 check("R9 unread words dropped at load start", 80'(out_avail), 80'(0));
                    if (flip) begin
                        cfg_in_wide  = ~iw;
                        cfg_cam_bits = 7'((cb + 37) % 81);
                    end
                end
            end
            in_valid = 1'b0;
            #1;
            check("R3 request raised", 80'(eng_req), 80'(1));
            check("R3 operation code", 80'(eng_op), 80'(tag));
            check("R2 CAM gathered", eng_cam, xcam);
            check("R5 RAM gathered, unsupplied zero", eng_ram, xram);
            in_valid = 1'b1;
            in_tag   = 3'd0;
            #1 check("R4 held off while issuing", 80'(in_ready), 80'(0));
            in_valid = 1'b0;
            for (int k = 0; k < wait_n; k++) begin
                @(posedge clk);
                @(negedge clk);
                #1 check("R3 request held", 80'({eng_req, eng_op}), 80'({1'b1, tag}));
            end
            eng_ack     = 1'b1;
            eng_rsp_cam = rc;
            eng_rsp_ram = rr;
            @(posedge clk);
            @(negedge clk);
            eng_ack = 1'b0;
            eng_rsp_cam = rnd80();
            eng_rsp_ram = rnd80();
        end else begin
            in_valid = 1'b1;
            in_tag   = tag;
            in_word  = $urandom();
            #1;
            check("R4 queue word held until ack", 80'(in_ready), 80'(0));
            check("R4 queue request immediate", 80'({eng_req, eng_op}), 80'({1'b1, tag}));
            for (int k = 0; k < wait_n; k++) begin
                @(posedge clk);
                @(negedge clk);
            end
            eng_ack     = 1'b1;
            eng_rsp_cam = rc;
            eng_rsp_ram = rr;
        end
        // expected unload sequence
        nseq = 0;
        if (isq) begin
            for (int k = 0; k < nwords(cb, ow); k++) begin
                exp_seq[nseq] = exp_word(rc, k, ow, cb);
                nseq++;
            end
        end
        if (isq || tag == 3'd1) begin
            for (int k = 0; k < nwords(80 - cb, ow); k++) begin
                exp_seq[nseq] = exp_word(rr, k, ow, 80 - cb);
                nseq++;
            end
        end
        start = 0;
        if (isq) begin
            #1;
            check("R4 queue word accepted at ack", 80'(in_ready), 80'(1));
            check("R7 first word available at request", 80'(out_avail), 80'(1));
            check("R7 first queue word", 80'(out_word), 80'(exp_seq[0]));
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            eng_ack  = 1'b0;
            eng_rsp_cam = rnd80();
            eng_rsp_ram = rnd80();
            start = 1;
        end
        if (flip) cfg_out_wide = ~ow;
        if (nseq == 0) begin
            #1 check("R11 nothing to unload", 80'(out_avail), 80'(0));
            check("R12 idle word zero", 80'(out_word), 80'(0));
        end
        j = start;
        if (rdn < 0) rdn = nseq;
        while (j < nseq && j - start < rdn) begin
            out_rd = 1'b1;
            #1;
            check("R9 word available", 80'(out_avail), 80'(1));
            check(isq ? "R7 queue word, R8 zero fill" : "R6 search word, R8 zero fill",
                  80'(out_word), 80'(exp_seq[j]));
            @(posedge clk);
            @(negedge clk);
            j++;
        end
        out_rd = 1'b0;
        #1 check("R9 remaining after reads", 80'(out_avail), 80'(j < nseq));
        if (j >= nseq) check("R12 word zero when empty", 80'(out_word), 80'(0));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset avail", 80'(out_avail), 80'(0));
        check("R1 reset request", 80'(eng_req), 80'(0));
        check("R1 reset ready", 80'(in_ready), 80'(0));
        check("R1 reset word", 80'(out_word), 80'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 80'({out_avail, eng_req, in_ready, out_word}), 80'(0));

        // directed corners
        run_op(3'd1, 80, 1'b0, 1'b0, -1, 0, -1, 1, 1'b0);  // R6 no RAM words
        run_op(3'd4, 0, 1'b1, 1'b1, -1, 0, -1, 0, 1'b0);   // R7 RAM only
        run_op(3'd2, 40, 1'b0, 1'b0, 0, 0, -1, 2, 1'b0);   // R5 insert without RAM
        run_op(3'd3, 80, 1'b0, 1'b1, -1, 1, -1, 0, 1'b0);  // R5 surplus word dropped
        run_op(3'd1, 100, 1'b1, 1'b0, -1, 0, -1, 0, 1'b0); // R2 split clamp
        run_op(3'd1, 24, 1'b1, 1'b0, -1, 0, -1, 1, 1'b1);  // R10 config change
        run_op(3'd5, 17, 1'b0, 1'b0, -1, 0, -1, 3, 1'b1);  // R8 partial words
        run_op(3'd1, 33, 1'b0, 1'b0, -1, 0, 1, 0, 1'b0);   // R9 early stop
        run_op(3'd2, 50, 1'b1, 1'b1, 1, 0, -1, 0, 1'b0);   // R9 abandon, R11

        for (int n = 0; n < 400; n++) begin
            logic [2:0] t;
            t = 3'($urandom_range(1, 5));
            run_op(t, $urandom_range(0, 80), 1'($urandom()), 1'($urandom()),
                   $urandom_range(0, 5), ($urandom_range(0, 7) == 0) ? 1 : 0,
                   ($urandom_range(0, 2) == 0) ? $urandom_range(0, 4) : -1,
                   $urandom_range(0, 3), 1'($urandom_range(0, 7) == 0));
        end

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule